// File: doc/BRIEF.md
# Aliased Register Slice with Atomic Bit Set, Clear and Masked Write

This block holds one 32-bit peripheral register that a simple memory-mapped bus reaches through up to four addresses within a 16-byte window. The base offset overwrites the whole register. Three further offsets each apply a single-cycle read-modify-write inside the block, so software never has to read, modify and write back. One offset ORs ones into the register, one clears the bits written as one, and one loads selected bits of the low half-word under a per-bit enable taken from the high half of the write data.

Internal logic can raise or drop status bits through dedicated set and clear vectors in the same cycle as a bus write. Each bit is merged on its own, so a hardware event on a bit the bus does not touch is never lost. Parameters select which aliases exist, which bits the bus cannot change (read-only), and which bits read back as zero (write-only). The hardware side always sees the full register value.

Top module: `reg_alias_slice`

## Requirements
- R1: While rst_ni is low, and after it is released, the register (reg_o) holds RESET_VAL until the first update.
- R2: A write at byte offset 0x0 loads every bus-writable bit from wdata_i.
- R3: A write at byte offset 0x4 sets each bus-writable bit whose wdata_i bit is 1 and leaves the other bits unchanged.
- R4: A write at byte offset 0x8 clears each bus-writable bit whose wdata_i bit is 1 and leaves the other bits unchanged.
- R5: A write at byte offset 0xC loads register bit i (i < 16) from wdata_i[i] where wdata_i[16+i] is 1, and leaves bits [31:16] and all non-enabled bits unchanged. For example, 0x0F000400 puts 4 into bits [11:8].
- R6: rdata_o always shows the current register value with the WO_MASK bits forced to zero, whatever the offset.
- R7: Bits set in RO_MASK are never changed by a bus write through any offset.
- R8: On a bit that no bus operation touches, hw_set_i forces a 1 and hw_clr_i forces a 0. If both are active on the same bit, the set wins.
- R9: When a bus operation and a hardware update hit the same bit in the same cycle, the bus result is kept on that bit. Hardware updates on the other bits still take effect.
- R10: A write to an offset whose alias is disabled by HAS_SET, HAS_CLR or HAS_MSK leaves the register unchanged apart from hardware updates.
- R11: reg_o shows the full register value, including the write-only bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | 1 for a write access, 0 for a read |
| bus_addr_i | input | OFFS_W | Byte offset in the window; bits [3:2] select the alias |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data: the register with write-only bits masked |
| hw_set_i | input | 32 | Per-bit set from internal logic |
| hw_clr_i | input | 32 | Per-bit clear from internal logic |
| reg_o | output | 32 | Full register value for internal logic |

## Verification
The hardest case to reach is a cycle in which a bus alias and hardware set and clear vectors all act at once, on overlapping and disjoint bits, so that the per-bit priority is visible. The bench drives long pseudo-random runs in which every cycle carries a random alias, random data and sparse random hardware vectors. It compares each cycle against an arithmetic model, and adds directed collisions on chosen bits. A second instance with every optional alias removed receives the same stimulus, which shows that writes to absent aliases are dropped.

// File: rtl/alias_pkg.sv
package alias_pkg;
  localparam int REG_W  = 32;
  localparam int HALF_W = REG_W / 2;

  typedef enum logic [1:0] {
    OP_ALL = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_MSK = 2'd3
  } alias_op_e;
endpackage

// File: rtl/alias_decode.sv
module alias_decode
  import alias_pkg::*;
#(
  parameter int OFFS_W  = 4,
  parameter bit HAS_SET = 1'b1,
  parameter bit HAS_CLR = 1'b1,
  parameter bit HAS_MSK = 1'b1
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [OFFS_W-1:0] addr_i,
  output logic              wr_en_o,
  output alias_op_e         op_o
);
  localparam int SEL_LSB = 2;

  logic present;

  assign op_o = alias_op_e'(addr_i[SEL_LSB+1:SEL_LSB]);

  always_comb begin
    unique case (op_o)
      OP_ALL:  present = 1'b1;
      OP_SET:  present = HAS_SET;
      OP_CLR:  present = HAS_CLR;
      OP_MSK:  present = HAS_MSK;
      default: present = 1'b0;
    endcase
  end

  assign wr_en_o = valid_i & write_i & present;
endmodule

// File: rtl/alias_wr_gen.sv
module alias_wr_gen
  import alias_pkg::*;
#(
  parameter logic [REG_W-1:0] RO_MASK = '0
) (
  input  logic             wr_en_i,
  input  alias_op_e        op_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] touch_o,
  output logic [REG_W-1:0] val_o
);
  logic [REG_W-1:0] raw_touch;

  always_comb begin
    raw_touch = '0;
    val_o     = '0;
    unique case (op_i)
      OP_ALL: begin raw_touch = '1;      val_o = wdata_i; end
      OP_SET: begin raw_touch = wdata_i; val_o = '1;      end
      OP_CLR: begin raw_touch = wdata_i; val_o = '0;      end
      OP_MSK: begin
        raw_touch = {{HALF_W{1'b0}}, wdata_i[REG_W-1:HALF_W]};
        val_o     = {{HALF_W{1'b0}}, wdata_i[HALF_W-1:0]};
      end
      default: ;
    endcase
  end

  assign touch_o = wr_en_i ? (raw_touch & ~RO_MASK) : '0;
endmodule

// File: rtl/alias_store.sv
module alias_store
  import alias_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] touch_i,
  input  logic [REG_W-1:0] val_i,
  input  logic [REG_W-1:0] hw_set_i,
  input  logic [REG_W-1:0] hw_clr_i,
  output logic [REG_W-1:0] q_o
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    logic d;
    // bus beats hardware; hardware set beats hardware clear
    always_comb begin
      if (touch_i[b])       d = val_i[b];
      else if (hw_set_i[b]) d = 1'b1;
      else if (hw_clr_i[b]) d = 1'b0;
      else                  d = q_o[b];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[b] <= RESET_VAL[b];
      else         q_o[b] <= d;
    end
  end
endmodule

// File: rtl/reg_alias_slice.sv
module reg_alias_slice
  import alias_pkg::*;
#(
  parameter int               OFFS_W    = 4,
  parameter bit               HAS_SET   = 1'b1,
  parameter bit               HAS_CLR   = 1'b1,
  parameter bit               HAS_MSK   = 1'b1,
  parameter logic [REG_W-1:0] RO_MASK   = 32'h0000_00F0,
  parameter logic [REG_W-1:0] WO_MASK   = 32'h0F00_0000,
  parameter logic [REG_W-1:0] RESET_VAL = 32'h0000_0050
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [OFFS_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic [REG_W-1:0]  hw_set_i,
  input  logic [REG_W-1:0]  hw_clr_i,
  output logic [REG_W-1:0]  reg_o
);
  logic             wr_en;
  alias_op_e        op;
  logic [REG_W-1:0] touch, val;

  alias_decode #(
    .OFFS_W(OFFS_W), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR), .HAS_MSK(HAS_MSK)
  ) i_decode (
    .valid_i(bus_valid_i), .write_i(bus_write_i), .addr_i(bus_addr_i),
    .wr_en_o(wr_en), .op_o(op)
  );

  alias_wr_gen #(.RO_MASK(RO_MASK)) i_wr_gen (
    .wr_en_i(wr_en), .op_i(op), .wdata_i(bus_wdata_i),
    .touch_o(touch), .val_o(val)
  );

  alias_store #(.RESET_VAL(RESET_VAL)) i_store (
    .clk_i, .rst_ni, .touch_i(touch), .val_i(val),
    .hw_set_i, .hw_clr_i, .q_o(reg_o)
  );

  assign bus_rdata_o = reg_o & ~WO_MASK;

  logic bus_wr, at_all, at_set, at_clr, at_msk;
  assign bus_wr = bus_valid_i & bus_write_i;
  assign at_all = bus_addr_i[3:2] == 2'd0;
  assign at_set = bus_addr_i[3:2] == 2'd1;
  assign at_clr = bus_addr_i[3:2] == 2'd2;
  assign at_msk = bus_addr_i[3:2] == 2'd3;

  AST_ALL_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr && at_all |=> ((reg_o ^ $past(bus_wdata_i)) & ~RO_MASK) == '0) else $error("all"); // R2

  AST_SET_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr && at_set && HAS_SET && hw_clr_i == '0
    |=> (reg_o & $past(reg_o | (bus_wdata_i & ~RO_MASK))) == $past(reg_o | (bus_wdata_i & ~RO_MASK))) else $error("set"); // R3

  AST_CLR_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr && at_clr && HAS_CLR |=> (reg_o & $past(bus_wdata_i & ~RO_MASK)) == '0) else $error("clr"); // R4

  AST_MSK_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr && at_msk && hw_set_i == '0 && hw_clr_i == '0
    |=> reg_o[REG_W-1:HALF_W] == $past(reg_o[REG_W-1:HALF_W])) else $error("msk"); // R5

  AST_RO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_i == '0 && hw_clr_i == '0 |=> (reg_o & RO_MASK) == $past(reg_o & RO_MASK)) else $error("ro"); // R7

  AST_HW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr |=> reg_o == (($past(reg_o) | $past(hw_set_i)) & ~($past(hw_clr_i) & ~$past(hw_set_i)))) else $error("hw"); // R8

  AST_ABSENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr && ((at_set && !HAS_SET) || (at_clr && !HAS_CLR) || (at_msk && !HAS_MSK))
    && hw_set_i == '0 && hw_clr_i == '0 |=> $stable(reg_o)) else $error("absent"); // R10
endmodule

// File: tb/test_reg_alias_slice.sv
module test_reg_alias_slice;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RO  = 32'h0000_00F0;
  localparam logic [31:0] WO  = 32'h0F00_0000;
  localparam logic [31:0] RST = 32'h0000_0050;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, hs = '0, hc = '0;
  logic [31:0] rdata_f, reg_f, rdata_m, reg_m;
  logic [31:0] m_full, m_min, seed;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_alias_slice #(.OFFS_W(4), .RO_MASK(RO), .WO_MASK(WO), .RESET_VAL(RST)) i_reg_alias_slice (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_f),
    .hw_set_i(hs), .hw_clr_i(hc), .reg_o(reg_f));

  reg_alias_slice #(.OFFS_W(4), .HAS_SET(1'b0), .HAS_CLR(1'b0), .HAS_MSK(1'b0),
                    .RO_MASK(RO), .WO_MASK(WO), .RESET_VAL(RST)) i_reg_alias_slice_min (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_m),
    .hw_set_i(hs), .hw_clr_i(hc), .reg_o(reg_m));

  function automatic logic [31:0] model(logic [31:0] m, logic v, logic w, logic [3:0] a,
                                        logic [31:0] d, logic [31:0] s, logic [31:0] c, bit full);
    logic [31:0] t, x, h;
    t = '0; x = '0;
    if (v && w) begin
      case (a[3:2])
        2'd0: begin t = 32'hFFFF_FFFF; x = d; end
        2'd1: if (full) begin t = d; x = 32'hFFFF_FFFF; end
        2'd2: if (full) begin t = d; x = '0; end
        default: if (full) begin t = {16'h0, d[31:16]}; x = {16'h0, d[15:0]}; end
      endcase
    end
    t = t & ~RO;
    h = (m | s) & ~(c & ~s);
    return (h & ~t) | (x & t);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic cyc(logic v, logic w, logic [3:0] a, logic [31:0] d,
                     logic [31:0] s, logic [31:0] c, string tag, string tag_min);
    @(negedge clk);
    valid = v; write = w; addr = a; wdata = d; hs = s; hc = c;
    m_full = model(m_full, v, w, a, d, s, c, 1'b1);
    m_min  = model(m_min,  v, w, a, d, s, c, 1'b0);
    @(posedge clk); #1;
    chk(tag, reg_f, m_full);
    chk("R6 rdata", rdata_f, m_full & ~WO);
    chk(tag_min, reg_m, m_min);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_full = RST; m_min = RST;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset reg", reg_f, RST);
    chk("R6 reset rdata", rdata_f, RST & ~WO);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", reg_f, RST);

    cyc(1, 1, 4'h0, 32'hFFFF_FFFF, 0, 0, "R2 all ones", "R2 min all");
    chk("R7 ro kept", reg_f & RO, RST & RO);
    chk("R11 wo visible", reg_f & WO, WO);
    chk("R6 wo hidden", rdata_f & WO, 32'h0);
    cyc(1, 1, 4'h0, 32'h0000_0000, 0, 0, "R2 all zeros", "R2 min zeros");
    cyc(1, 1, 4'hC, 32'h0F00_0400, 0, 0, "R5 msk example", "R10 msk absent");
    chk("R5 field", reg_f, RST & RO | 32'h0000_0400);
    cyc(1, 1, 4'h4, 32'hA000_0003, 0, 0, "R3 set", "R10 set absent");
    cyc(1, 1, 4'h8, 32'h2000_0401, 0, 0, "R4 clr", "R10 clr absent");
    cyc(1, 0, 4'h0, 32'hFFFF_FFFF, 0, 0, "R6 read no change", "R6 min read");
    // collisions: bus set on bit 1, hw clears bit 1; hw sets bit 30 untouched
    cyc(1, 1, 4'h4, 32'h0000_0002, 32'h4000_0000, 32'h0000_0002, "R9 set vs hwclr", "R9 min");
    chk("R9 both effects", reg_f[30] & reg_f[1], 1'b1);
    cyc(1, 1, 4'h8, 32'h4000_0000, 32'h4000_0100, 0, "R9 clr vs hwset", "R9 min2");
    chk("R9 bus wins", {reg_f[30], reg_f[8]}, 2'b01);
    cyc(0, 0, 4'h0, 0, 32'h0000_0010, 32'h0000_0110, "R8 set beats clr", "R8 min");
    chk("R8 ro by hw", reg_f[4], 1'b1);
    cyc(1, 1, 4'h4, 32'h0000_00F0, 0, 0, "R7 set on ro", "R7 min");
    cyc(1, 1, 4'h8, 32'h0000_00F0, 0, 0, "R7 clr on ro", "R7 min2");

    seed = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r1, r2, r3, r4;
      string tg;
      seed = rnd(seed); r1 = seed;
      seed = rnd(seed); r2 = seed;
      seed = rnd(seed); r3 = seed;
      seed = rnd(seed); r4 = seed;
      case (r1[3:2])
        2'd0: tg = "R2 sweep";
        2'd1: tg = "R3 sweep";
        2'd2: tg = "R4 sweep";
        default: tg = "R5 sweep";
      endcase
      if (!(r1[8] & r1[9])) tg = "R8 sweep";
      cyc(r1[8], r1[9], r1[3:0], r2, r3 & r4 & {32{r1[10]}}, r3 & ~r4 & rnd(r4), tg, "R10 sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule